// File: doc/BRIEF.md
# AAL1 Sequence Count Tracker

This block follows the 3-bit sequence count of the cells arriving on one AAL1 reassembly channel. For every arriving cell it takes the count and a flag that tells whether the count's protection field checked out. It then decides whether the cell goes on to reassembly or is dropped. When a channel has held lock but no cell arrives within a programmable number of idle cycles, it asks for a dummy cell. Dummy cells carry user-programmable fill data, which another block produces. The tracker keeps the expected count moving past the inserted dummy.

Once an out-of-order cell breaks lock, a recovery state uses the next cell to tell a single lost cell from a misinserted cell or a failed protection check. A separate state after a dummy insertion decides whether the cell the dummy replaced has simply arrived late. One-cycle pulses report lost cells, misinserted cells, late cells and AAL1 sequence errors.

All verdicts and pulses are registered. They appear in the clock cycle after the edge that samples the cell, or after the edge at which the timeout fires. All count comparisons wrap modulo 8.

Top module: `aal1_sn_tracker`

## Requirements
- R1: While `rst_n` is low, all seven outputs are 0, and the tracker starts out in the hunting (unlocked) state.
- R2: While hunting, a cell with `sn_ok` high is accepted (`cell_accept`) and locks the tracker with the expected count set to its count plus 1. A cell with `sn_ok` low is discarded (`cell_discard`) and the tracker keeps hunting.
- R3: While locked, a valid cell whose count equals the expected count is accepted, and the expected count advances by 1 modulo 8 (7 is followed by 0).
- R4: While locked, a valid cell whose count differs from the expected count is discarded, its count is recorded as the last received count, and the tracker enters recovery.
- R5: In recovery, a valid cell whose count is the last received count plus 1 is accepted with `lost_pulse`. The tracker relocks expecting that count plus 1.
- R6: In recovery, a valid cell whose count equals the expected count is discarded with `misins_pulse`. The tracker relocks expecting that count plus 1.
- R7: In recovery, a valid cell whose count is the expected count plus 1 is discarded with no error pulse. The tracker relocks expecting that count plus 1.
- R8: In recovery, any other valid cell is discarded and the tracker loses sync. While sync is lost, any cell is discarded and the tracker returns to hunting.
- R9: In recovery, in lost sync and in the late-cell state, a cell with `sn_ok` low is discarded and the tracker returns to hunting.
- R10: The timeout counter reloads from `tmo_cycles` on every cell that leaves the tracker locked. If `tmo_cycles`+1 idle cycles pass while locked, `insert_dummy` pulses alone. The expected count then advances by 1, the replaced count is saved as the original count, and the tracker enters the late-cell state. No timeout runs outside the locked state.
- R11: In the late-cell state, a valid cell carrying the original count is discarded with `late_pulse`, and the tracker relocks expecting the original count plus 1.
- R12: In the late-cell state, a valid cell carrying the original count plus 1 is accepted with both `lost_pulse` and `seq_err_pulse`. The tracker relocks expecting that count plus 1.
- R13: In the late-cell state, any other valid cell is discarded with `seq_err_pulse`, and the tracker loses sync.
- R14: While locked, a cell with `sn_ok` low is discarded, leaves the expected count unchanged and keeps the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_vld | input | 1 | A cell is presented this cycle |
| cell_sn | input | SN_W (3) | Sequence count of the presented cell |
| sn_ok | input | 1 | The count passed its protection check |
| tmo_cycles | input | TMR_W (16) | Idle-cycle timeout reload value |
| cell_accept | output | 1 | Cell goes to reassembly (pulse) |
| cell_discard | output | 1 | Cell is dropped (pulse) |
| insert_dummy | output | 1 | Request for one dummy cell (pulse) |
| lost_pulse | output | 1 | Lost cell detected |
| misins_pulse | output | 1 | Misinserted cell detected |
| late_pulse | output | 1 | Late cell detected |
| seq_err_pulse | output | 1 | AAL1 sequence error |

## Verification
Every cycle, the assertions check the local rules of the verdicts. Each cell gets exactly one of accept or discard, a failed protection check always discards, and a dummy request only ever follows an idle cycle and never repeats on consecutive cycles. Each error pulse rides on the matching verdict: lost on accept, misinsertion and late on discard. Which branch a given count takes depends on the remembered expected, last-received and original counts, so only the bench's cell sequences can show it. The same holds for the exact cycle at which the timeout fires, and for the tracker returning to hunting, which shows only as a later cell being accepted.

// File: rtl/aal1_sn_pkg.sv
package aal1_sn_pkg;

  typedef enum logic [2:0] {
    ST_HUNT      = 3'd0,
    ST_LOCK      = 3'd1,
    ST_RECOVER   = 3'd2,
    ST_LOST_SYNC = 3'd3,
    ST_LATE_WAIT = 3'd4
  } sn_state_e;

  typedef struct packed {
    logic acc;
    logic dis;
    logic ins;
    logic lost;
    logic mis;
    logic late;
    logic serr;
  } sn_verdict_t;

endpackage

// File: rtl/aal1_sn_match.sv
module aal1_sn_match #(
  parameter int SN_W = 3
) (
  input  logic [SN_W-1:0] cell_sn,
  input  logic [SN_W-1:0] exp_sn,
  input  logic [SN_W-1:0] last_sn,
  input  logic [SN_W-1:0] orig_sn,
  output logic [SN_W-1:0] sn_p1,
  output logic [SN_W-1:0] exp_p1,
  output logic            hit_exp,
  output logic            hit_exp_p1,
  output logic            hit_last_p1,
  output logic            hit_orig,
  output logic            hit_orig_p1
);
  localparam logic [SN_W-1:0] ONE = SN_W'(1);

  // all sums wrap at the count width
  always_comb begin
    sn_p1       = cell_sn + ONE;
    exp_p1      = exp_sn + ONE;
    hit_exp     = (cell_sn == exp_sn);
    hit_exp_p1  = (cell_sn == exp_p1);
    hit_last_p1 = (cell_sn == last_sn + ONE);
    hit_orig    = (cell_sn == orig_sn);
    hit_orig_p1 = (cell_sn == orig_sn + ONE);
  end
endmodule

// File: rtl/aal1_sn_timer.sv
module aal1_sn_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/aal1_sn_tracker.sv
module aal1_sn_tracker
  import aal1_sn_pkg::*;
#(
  parameter int SN_W  = 3,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_vld,
  input  logic [SN_W-1:0]  cell_sn,
  input  logic             sn_ok,
  input  logic [TMR_W-1:0] tmo_cycles,
  output logic             cell_accept,
  output logic             cell_discard,
  output logic             insert_dummy,
  output logic             lost_pulse,
  output logic             misins_pulse,
  output logic             late_pulse,
  output logic             seq_err_pulse
);
  sn_state_e   st_q, st_d;
  logic [SN_W-1:0] exp_q, exp_d, last_q, last_d, orig_q, orig_d;
  sn_verdict_t vd_d, vd_q;

  logic [SN_W-1:0] sn_p1, exp_p1;
  logic hit_exp, hit_exp_p1, hit_last_p1, hit_orig, hit_orig_p1;
  logic tmr_zero, tmr_load, tmr_dec, expire, ctx_en;

  aal1_sn_match #(.SN_W(SN_W)) u_match (
    .cell_sn     (cell_sn),
    .exp_sn      (exp_q),
    .last_sn     (last_q),
    .orig_sn     (orig_q),
    .sn_p1       (sn_p1),
    .exp_p1      (exp_p1),
    .hit_exp     (hit_exp),
    .hit_exp_p1  (hit_exp_p1),
    .hit_last_p1 (hit_last_p1),
    .hit_orig    (hit_orig),
    .hit_orig_p1 (hit_orig_p1)
  );

  aal1_sn_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmo_cycles),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  // timeout only counts while locked and idle
  assign expire   = (st_q == ST_LOCK) && !cell_vld && tmr_zero;
  assign tmr_dec  = (st_q == ST_LOCK) && !cell_vld && !tmr_zero;
  assign tmr_load = cell_vld && (st_d == ST_LOCK);
  assign ctx_en   = cell_vld | expire;

  // next-state and verdict
  always_comb begin
    st_d   = st_q;
    exp_d  = exp_q;
    last_d = last_q;
    orig_d = orig_q;
    vd_d   = '0;
    if (expire) begin
      vd_d.ins = 1'b1;
      orig_d   = exp_q;
      exp_d    = exp_p1;
      st_d     = ST_LATE_WAIT;
    end else if (cell_vld) begin
      unique case (st_q)
        ST_HUNT: begin
          if (sn_ok) begin
            vd_d.acc = 1'b1;
            exp_d    = sn_p1;
            st_d     = ST_LOCK;
          end else begin
            vd_d.dis = 1'b1;
          end
        end
        ST_LOCK: begin
          if (!sn_ok) begin
            vd_d.dis = 1'b1;
          end else if (hit_exp) begin
            vd_d.acc = 1'b1;
            exp_d    = sn_p1;
          end else begin
            vd_d.dis = 1'b1;
            last_d   = cell_sn;
            st_d     = ST_RECOVER;
          end
        end
        ST_RECOVER: begin
          vd_d.dis = 1'b1;
          if (!sn_ok) begin
            st_d = ST_HUNT;
          end else if (hit_last_p1) begin
            vd_d.dis  = 1'b0;
            vd_d.acc  = 1'b1;
            vd_d.lost = 1'b1;
            exp_d     = sn_p1;
            st_d      = ST_LOCK;
          end else if (hit_exp) begin
            vd_d.mis = 1'b1;
            exp_d    = sn_p1;
            st_d     = ST_LOCK;
          end else if (hit_exp_p1) begin
            exp_d = sn_p1;
            st_d  = ST_LOCK;
          end else begin
            st_d = ST_LOST_SYNC;
          end
        end
        ST_LOST_SYNC: begin
          vd_d.dis = 1'b1;
          st_d     = ST_HUNT;
        end
        ST_LATE_WAIT: begin
          vd_d.dis = 1'b1;
          if (!sn_ok) begin
            st_d = ST_HUNT;
          end else if (hit_orig_p1) begin
            vd_d.dis  = 1'b0;
            vd_d.acc  = 1'b1;
            vd_d.lost = 1'b1;
            vd_d.serr = 1'b1;
            exp_d     = sn_p1;
            st_d      = ST_LOCK;
          end else if (hit_orig) begin
            vd_d.late = 1'b1;
            st_d      = ST_LOCK;
          end else begin
            vd_d.serr = 1'b1;
            st_d      = ST_LOST_SYNC;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HUNT;
      vd_q <= '0;
    end else begin
      st_q <= st_d;
      vd_q <= vd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= '0;
      last_q <= '0;
      orig_q <= '0;
    end else if (ctx_en) begin
      exp_q  <= exp_d;
      last_q <= last_d;
      orig_q <= orig_d;
    end
  end

  assign cell_accept   = vd_q.acc;
  assign cell_discard  = vd_q.dis;
  assign insert_dummy  = vd_q.ins;
  assign lost_pulse    = vd_q.lost;
  assign misins_pulse  = vd_q.mis;
  assign late_pulse    = vd_q.late;
  assign seq_err_pulse = vd_q.serr;
endmodule

// File: rtl/aal1_sn_tracker_chk.sv
module aal1_sn_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_vld,
  input logic sn_ok,
  input logic cell_accept,
  input logic cell_discard,
  input logic insert_dummy,
  input logic lost_pulse,
  input logic misins_pulse,
  input logic late_pulse
);
  // R3: every cell gets exactly one verdict
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    cell_vld |=> (cell_accept ^ cell_discard));

  // R3: no verdict without a cell
  a_r3_verdict_needs_cell: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_accept || cell_discard) |-> $past(cell_vld));

  // R9 / R14: failed protection always discards
  a_r9_bad_sn_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && !sn_ok) |=> (cell_discard && !cell_accept));

  // R10: dummy request follows an idle cycle only
  a_r10_dummy_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    insert_dummy |-> (!$past(cell_vld) && !cell_accept && !cell_discard));

  // R10: at most one dummy per timeout episode
  a_r10_single_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    insert_dummy |=> !insert_dummy);

  // R5: lost cell goes with acceptance
  a_r5_lost_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    lost_pulse |-> cell_accept);

  // R6: misinsertion goes with discard
  a_r6_mis_discards: assert property (@(posedge clk) disable iff (!rst_n)
    misins_pulse |-> cell_discard);

  // R11: late cell goes with discard
  a_r11_late_discards: assert property (@(posedge clk) disable iff (!rst_n)
    late_pulse |-> cell_discard);
endmodule

bind aal1_sn_tracker aal1_sn_tracker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cell_vld     (cell_vld),
  .sn_ok        (sn_ok),
  .cell_accept  (cell_accept),
  .cell_discard (cell_discard),
  .insert_dummy (insert_dummy),
  .lost_pulse   (lost_pulse),
  .misins_pulse (misins_pulse),
  .late_pulse   (late_pulse)
);

// File: tb/tb_aal1_sn_tracker.sv
`timescale 1ns/1ps
module tb_aal1_sn_tracker;
  localparam logic [6:0] V_ACC  = 7'b1000000;
  localparam logic [6:0] V_DIS  = 7'b0100000;
  localparam logic [6:0] V_INS  = 7'b0010000;
  localparam logic [6:0] V_LOST = 7'b0001000;
  localparam logic [6:0] V_MIS  = 7'b0000100;
  localparam logic [6:0] V_LATE = 7'b0000010;
  localparam logic [6:0] V_SERR = 7'b0000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_vld = 1'b0;
  logic [2:0] cell_sn = '0;
  logic sn_ok = 1'b0;
  logic [15:0] tmo_cycles = 16'd1000;
  logic cell_accept, cell_discard, insert_dummy, lost_pulse, misins_pulse, late_pulse, seq_err_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_cyc = 0;
  bit done = 1'b0;

  logic [6:0] q_bits[$];
  int         q_cyc[$];
  string      q_tag[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  aal1_sn_tracker dut (
    .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_sn(cell_sn), .sn_ok(sn_ok),
    .tmo_cycles(tmo_cycles), .cell_accept(cell_accept), .cell_discard(cell_discard),
    .insert_dummy(insert_dummy), .lost_pulse(lost_pulse), .misins_pulse(misins_pulse),
    .late_pulse(late_pulse), .seq_err_pulse(seq_err_pulse)
  );

  function automatic logic [6:0] outs();
    return {cell_accept, cell_discard, insert_dummy, lost_pulse, misins_pulse, late_pulse, seq_err_pulse};
  endfunction

  task automatic push(input logic [6:0] v, input int c, input string tag);
    q_bits.push_back(v);
    q_cyc.push_back(c);
    q_tag.push_back(tag);
  endtask

  // monitor: compares produced verdicts against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (q_cyc.size() != 0 && q_cyc[0] < cyc) begin
        checks++; fails++;
        $display("FAIL %s: missing verdict at cycle %0d, actual none expected %b", q_tag[0], q_cyc[0], q_bits[0]);
        void'(q_bits.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
      end
      if (outs() != 7'b0) begin
        checks++;
        if (q_bits.size() == 0) begin
          fails++;
          $display("FAIL unexpected output at cycle %0d: actual %b expected %b", cyc, outs(), 7'b0);
        end else begin
          if (outs() != q_bits[0] || q_cyc[0] != cyc) begin
            fails++;
            $display("FAIL %s: actual %b at cycle %0d expected %b at cycle %0d",
                     q_tag[0], outs(), cyc, q_bits[0], q_cyc[0]);
          end
          void'(q_bits.pop_front()); void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  task automatic send(input logic [2:0] sn, input logic ok, input logic [6:0] v, input string tag);
    @(negedge clk);
    cell_vld = 1'b1; cell_sn = sn; sn_ok = ok;
    @(posedge clk); #1;
    push(v, cyc, tag);
    last_cyc = cyc;
    @(negedge clk);
    cell_vld = 1'b0; sn_ok = 1'b0;
  endtask

  task automatic expect_dummy(input string tag);
    push(V_INS, last_cyc + int'(tmo_cycles) + 1, tag);
    repeat (int'(tmo_cycles) + 2) @(negedge clk);
  endtask

  task automatic do_reset(input int to);
    @(negedge clk);
    rst_n = 1'b0;
    tmo_cycles = 16'(to);
    repeat (2) @(negedge clk);
    checks++;
    if (outs() != 7'b0) begin
      fails++;
      $display("FAIL R1: outputs in reset actual %b expected %b", outs(), 7'b0);
    end
    if (q_bits.size() != 0) begin
      fails++;
      $display("FAIL leftover expectation %s: actual pending %0d expected 0", q_tag[0], q_bits.size());
      q_bits.delete(); q_cyc.delete(); q_tag.delete();
    end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1, R2, R3, R14
    do_reset(1000);
    send(3'd4, 1'b0, V_DIS, "R2 bad cell while hunting");
    send(3'd5, 1'b1, V_ACC, "R2 first valid cell locks");
    send(3'd6, 1'b1, V_ACC, "R3 in order");
    send(3'd7, 1'b1, V_ACC, "R3 in order");
    send(3'd0, 1'b1, V_ACC, "R3 wrap 7->0");
    send(3'd1, 1'b1, V_ACC, "R3 after wrap");
    send(3'd3, 1'b0, V_DIS, "R14 bad cell in lock");
    send(3'd2, 1'b1, V_ACC, "R14 expected count unchanged");

    // R4, R5
    do_reset(1000);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    send(3'd5, 1'b1, V_DIS, "R4 out of order");
    send(3'd6, 1'b1, V_ACC | V_LOST, "R5 single loss");
    send(3'd7, 1'b1, V_ACC, "R5 relocked at 7");

    // R6
    do_reset(1000);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    send(3'd6, 1'b1, V_DIS, "R4 out of order");
    send(3'd3, 1'b1, V_DIS | V_MIS, "R6 misinsertion");
    send(3'd4, 1'b1, V_ACC, "R6 relocked at 4");

    // R7
    do_reset(1000);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    send(3'd6, 1'b1, V_DIS, "R4 out of order");
    send(3'd4, 1'b1, V_DIS, "R7 protection failure");
    send(3'd5, 1'b1, V_ACC, "R7 relocked at 5");

    // R8
    do_reset(1000);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    send(3'd6, 1'b1, V_DIS, "R4 out of order");
    send(3'd0, 1'b1, V_DIS, "R8 other count");
    send(3'd1, 1'b1, V_DIS, "R8 lost sync drops cell");
    send(3'd3, 1'b1, V_ACC, "R8 back to hunting");

    // R9 in recovery
    do_reset(1000);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    send(3'd6, 1'b1, V_DIS, "R4 out of order");
    send(3'd5, 1'b0, V_DIS, "R9 bad cell in recovery");
    send(3'd1, 1'b1, V_ACC, "R9 back to hunting");

    // R10, R11
    do_reset(4);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    send(3'd3, 1'b1, V_ACC, "R10 cell reloads timer");
    send(3'd4, 1'b1, V_ACC, "R10 cell reloads timer");
    expect_dummy("R10 timeout dummy");
    send(3'd5, 1'b1, V_DIS | V_LATE, "R11 late cell");
    send(3'd6, 1'b1, V_ACC, "R11 relocked at 6");

    // R12
    do_reset(4);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    expect_dummy("R10 timeout dummy");
    send(3'd4, 1'b1, V_ACC | V_LOST | V_SERR, "R12 one past original");
    send(3'd5, 1'b1, V_ACC, "R12 relocked at 5");

    // R13
    do_reset(4);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    expect_dummy("R10 timeout dummy");
    send(3'd7, 1'b1, V_DIS | V_SERR, "R13 other count");
    send(3'd0, 1'b1, V_DIS, "R13 lost sync drops cell");
    send(3'd6, 1'b1, V_ACC, "R13 back to hunting");

    // R10 no timer outside lock, R9 in late state
    do_reset(4);
    send(3'd2, 1'b1, V_ACC, "R2 lock at 2");
    expect_dummy("R10 timeout dummy");
    repeat (20) @(negedge clk);
    send(3'd1, 1'b0, V_DIS, "R9 bad cell in late state");
    send(3'd6, 1'b1, V_ACC, "R9 back to hunting");

    do_reset(1000);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule